// File: doc/BRIEF.md
# Switch-on-Event Thread Controller

This controller runs a coarse-grained multithreaded pipeline. One hardware thread owns the pipeline until something expensive happens to it: a long-latency cache miss, a synchronization wait, or a switch instruction. A time slice that runs out also ends its turn. When any of these occurs, the controller records the PC at which the thread must resume. It then asks the pipeline to drain and waits until the pipeline reports that it is empty. Next it chooses the next thread and, for one cycle, presents that thread's restart PC to fetch. The new thread then owns the pipeline.

The choice of next thread has two levels. A thread is eligible when it is externally ready and not blocked. Among eligible threads, the ones with their critical bit set win. Ties are broken round-robin, starting with the thread after the one that just ran, so the old thread is considered last. A thread that left on a miss or a synchronization wait stays blocked until its wake bit pulses. The time-slice length comes from a quantum register that a write strobe loads, and each refill restarts the slice from that register.

The controller cycles through three states. RUN means a thread owns the pipeline. DRAIN means the controller is waiting for the pipeline to empty and for an eligible thread. REFILL lasts one cycle and issues the restart PC. The transitions are RUN to DRAIN on an event or slice expiry, DRAIN to REFILL when the pipeline is empty and some thread is eligible, and REFILL to RUN always. Reset places the controller in DRAIN with thread N-1 recorded as the last owner, so the first pick starts at thread 0.

Top module: `soe_thread_ctrl`

## Requirements
- R1: During and right after reset, drain_req is 1, act_valid is 0 and restart_valid is 0; the first refill picks as if thread N-1 had just run.
- R2: In RUN, a cycle with ev_miss, ev_sync or ev_swi at 1 moves the controller to DRAIN in the next cycle (drain_req=1, act_valid=0).
- R3: DRAIN persists while pipe_empty is 0, and also while pipe_empty is 1 but no thread is eligible (thr_ready bit 1 and not blocked).
- R4: DRAIN with pipe_empty=1 and at least one eligible thread leads to exactly one REFILL cycle (restart_valid=1), followed by RUN (act_valid=1).
- R5: In REFILL, restart_pc equals the cur_pc sampled in the cycle that thread last left RUN. A thread that has never run gets BOOT_PC + tid*BOOT_STRIDE instead.
- R6: Leaving RUN on ev_miss or ev_sync blocks the thread until a cycle with its thr_wake bit at 1. Leaving on ev_swi or slice expiry does not block it.
- R7: The next thread is the first eligible thread with thr_prio at 1 in the order act_tid+1, act_tid+2, ... modulo N, ending with act_tid itself. If no eligible thread has thr_prio at 1, it is the first eligible thread in the same order.
- R8: With no event, a thread is preempted after exactly Q cycles in RUN, where Q is the quantum register value when its REFILL occurred; Q=0 behaves as 1.
- R9: A write with q_we=1 changes only the slice of later refills. Events raised outside RUN are ignored: they neither save a PC nor block a thread.
- R10: act_tid changes only on entry to REFILL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ev_miss | input | 1 | Active thread took a long cache miss |
| ev_sync | input | 1 | Active thread waits on a synchronization location |
| ev_swi | input | 1 | Active thread executed a switch instruction |
| cur_pc | input | PC_W | Resume PC of the active thread, sampled at the switch |
| thr_ready | input | N | Per-thread external ready bits |
| thr_prio | input | N | Per-thread critical (high priority) bits |
| thr_wake | input | N | Per-thread wake pulses that clear the blocked flag |
| pipe_empty | input | 1 | Pipeline holds no in-flight instruction |
| q_we | input | 1 | Load the quantum register |
| q_val | input | SLICE_W | New quantum value |
| act_tid | output | TW | Owning / selected thread id |
| act_valid | output | 1 | RUN: act_tid owns the pipeline |
| drain_req | output | 1 | DRAIN: pipeline must drain |
| restart_valid | output | 1 | REFILL: fetch must restart at restart_pc |
| restart_pc | output | PC_W | Restart PC of act_tid |

## Verification
The hardest situation to reach from the ports is a DRAIN in which the pipeline is already empty but every ready thread is blocked. Every thread must first leave on a miss or a synchronization wait without being woken. The stimulus reaches this case with a long pseudo-random series of switches whose event kinds, ready masks, priority masks and wake pulses all come from one LFSR. Whenever no eligible thread is left, it holds pipe_empty high for a while and only then pulses the wake bits. Each pick is predicted by a blocked-set model in the bench.

// File: rtl/soe_pkg.sv
package soe_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_REFILL = 2'd2
    } soe_state_e;

endpackage

// File: rtl/soe_pick.sv
// Next-thread selector: critical threads first, round-robin after cur.
module soe_pick #(
    parameter  int N  = 4,
    localparam int TW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  elig,
    input  logic [N-1:0]  prio,
    input  logic [TW-1:0] cur,
    output logic          any,
    output logic [TW-1:0] pick
);

    logic          hi_found;
    logic          lo_found;
    logic [TW-1:0] hi_tid;
    logic [TW-1:0] lo_tid;

    always_comb begin
        hi_found = 1'b0;
        lo_found = 1'b0;
        hi_tid   = '0;
        lo_tid   = '0;
        for (int i = 1; i <= N; i++) begin
            int j;
            j = (int'(cur) + i) % N;
            if (elig[j] && !lo_found) begin
                lo_found = 1'b1;
                lo_tid   = TW'(j);
            end
            if (elig[j] && prio[j] && !hi_found) begin
                hi_found = 1'b1;
                hi_tid   = TW'(j);
            end
        end
        any  = |elig;
        pick = hi_found ? hi_tid : lo_tid;
    end

endmodule

// File: rtl/soe_slice.sv
// Time-slice down counter, reloaded at each refill.
module soe_slice #(
    parameter int SLICE_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               run,
    input  logic [SLICE_W-1:0] quantum,
    output logic               expired
);

    logic [SLICE_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= quantum;
        end else if (run && cnt_q > SLICE_W'(1)) begin
            cnt_q <= cnt_q - SLICE_W'(1);
        end
    end

    assign expired = run && (cnt_q <= SLICE_W'(1));

endmodule

// File: rtl/soe_ctx.sv
// Per-thread resume PC and blocked flag.
module soe_ctx #(
    parameter  int              N           = 4,
    parameter  int              PC_W        = 32,
    parameter  logic [PC_W-1:0] BOOT_PC     = '0,
    parameter  logic [PC_W-1:0] BOOT_STRIDE = '0,
    localparam int              TW          = (N > 1) ? $clog2(N) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_en,
    input  logic            block_en,
    input  logic [TW-1:0]   save_tid,
    input  logic [PC_W-1:0] save_pc,
    input  logic [N-1:0]    wake,
    input  logic [TW-1:0]   rd_tid,
    output logic [PC_W-1:0] rd_pc,
    output logic [N-1:0]    blocked
);

    logic [PC_W-1:0] pc_q [N];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int t = 0; t < N; t++) begin
                pc_q[t] <= BOOT_PC + PC_W'(t) * BOOT_STRIDE;
            end
        end else if (save_en) begin
            pc_q[save_tid] <= save_pc;
        end
    end

    for (genvar g = 0; g < N; g++) begin : g_blk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                blocked[g] <= 1'b0;
            end else if (block_en && save_tid == TW'(g)) begin
                blocked[g] <= 1'b1;
            end else if (wake[g]) begin
                blocked[g] <= 1'b0;
            end
        end
    end

    assign rd_pc = pc_q[rd_tid];

endmodule

// File: rtl/soe_thread_ctrl.sv
module soe_thread_ctrl
    import soe_pkg::*;
#(
    parameter  int              N           = 4,
    parameter  int              PC_W        = 32,
    parameter  int              SLICE_W     = 16,
    parameter  logic [PC_W-1:0] BOOT_PC     = 32'h0000_1000,
    parameter  logic [PC_W-1:0] BOOT_STRIDE = 32'h0000_1000,
    parameter  int              DEF_QUANTUM = 1000,
    localparam int              TW          = (N > 1) ? $clog2(N) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ev_miss,
    input  logic               ev_sync,
    input  logic               ev_swi,
    input  logic [PC_W-1:0]    cur_pc,
    input  logic [N-1:0]       thr_ready,
    input  logic [N-1:0]       thr_prio,
    input  logic [N-1:0]       thr_wake,
    input  logic               pipe_empty,
    input  logic               q_we,
    input  logic [SLICE_W-1:0] q_val,
    output logic [TW-1:0]      act_tid,
    output logic               act_valid,
    output logic               drain_req,
    output logic               restart_valid,
    output logic [PC_W-1:0]    restart_pc
);

    soe_state_e         state_q, state_d;
    logic [TW-1:0]      tid_q;
    logic [SLICE_W-1:0] quantum_q;

    logic               slice_out;
    logic               switch_go;
    logic               block_go;
    logic               start_refill;
    logic [N-1:0]       blocked;
    logic [N-1:0]       elig;
    logic               any_elig;
    logic [TW-1:0]      next_tid;

    assign switch_go    = (state_q == ST_RUN) && (ev_miss || ev_sync || ev_swi || slice_out);
    assign block_go     = switch_go && (ev_miss || ev_sync);
    assign elig         = thr_ready & ~blocked;
    assign start_refill = (state_q == ST_DRAIN) && pipe_empty && any_elig;

    soe_ctx #(
        .N(N), .PC_W(PC_W), .BOOT_PC(BOOT_PC), .BOOT_STRIDE(BOOT_STRIDE)
    ) u_ctx (
        .clk      (clk),
        .rst_n    (rst_n),
        .save_en  (switch_go),
        .block_en (block_go),
        .save_tid (tid_q),
        .save_pc  (cur_pc),
        .wake     (thr_wake),
        .rd_tid   (tid_q),
        .rd_pc    (restart_pc),
        .blocked  (blocked)
    );

    soe_pick #(.N(N)) u_pick (
        .elig (elig),
        .prio (thr_prio),
        .cur  (tid_q),
        .any  (any_elig),
        .pick (next_tid)
    );

    soe_slice #(.SLICE_W(SLICE_W)) u_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (state_q == ST_REFILL),
        .run     (state_q == ST_RUN),
        .quantum (quantum_q),
        .expired (slice_out)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:    if (switch_go)    state_d = ST_DRAIN;
            ST_DRAIN:  if (start_refill) state_d = ST_REFILL;
            ST_REFILL:                   state_d = ST_RUN;
            default:                     state_d = ST_DRAIN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_DRAIN;
            tid_q     <= TW'(N - 1);
            quantum_q <= SLICE_W'(DEF_QUANTUM);
        end else begin
            state_q <= state_d;
            if (start_refill) tid_q <= next_tid;
            if (q_we) quantum_q <= q_val;
        end
    end

    always_comb begin
        act_valid     = 1'b0;
        drain_req     = 1'b0;
        restart_valid = 1'b0;
        unique case (state_q)
            ST_RUN:    act_valid     = 1'b1;
            ST_DRAIN:  drain_req     = 1'b1;
            ST_REFILL: restart_valid = 1'b1;
            default:   drain_req     = 1'b1;
        endcase
    end

    assign act_tid = tid_q;

endmodule

// File: rtl/soe_thread_ctrl_chk.sv
module soe_thread_ctrl_chk #(
    parameter int TW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_miss,
    input logic          ev_sync,
    input logic          ev_swi,
    input logic          pipe_empty,
    input logic [TW-1:0] act_tid,
    input logic          act_valid,
    input logic          drain_req,
    input logic          restart_valid
);

    a_r2_event_drains: assert property (@(posedge clk) disable iff (!rst_n)
        act_valid && (ev_miss || ev_sync || ev_swi) |=> drain_req);

    a_r3_wait_empty: assert property (@(posedge clk) disable iff (!rst_n)
        drain_req && !pipe_empty |=> drain_req);

    a_r4_refill_to_run: assert property (@(posedge clk) disable iff (!rst_n)
        restart_valid |=> act_valid);

    a_r4_refill_from_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(restart_valid) |-> $past(drain_req));

    a_r10_tid_on_refill: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_tid) |-> restart_valid);

endmodule

bind soe_thread_ctrl soe_thread_ctrl_chk #(.TW(TW)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ev_miss       (ev_miss),
    .ev_sync       (ev_sync),
    .ev_swi        (ev_swi),
    .pipe_empty    (pipe_empty),
    .act_tid       (act_tid),
    .act_valid     (act_valid),
    .drain_req     (drain_req),
    .restart_valid (restart_valid)
);

// File: tb/soe_thread_ctrl_tb_top.sv
`timescale 1ns/1ps
module soe_thread_ctrl_tb_top;

    localparam int N = 4;
    localparam int PC_W = 16;
    localparam int SW = 8;
    localparam logic [15:0] BPC = 16'h1000;
    localparam logic [15:0] BST = 16'h0200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ev_miss = 0, ev_sync = 0, ev_swi = 0;
    logic [PC_W-1:0] cur_pc = '0;
    logic [N-1:0] thr_ready = '0, thr_prio = '0, thr_wake = '0;
    logic pipe_empty = 1'b0;
    logic q_we = 1'b0;
    logic [SW-1:0] q_val = '0;
    logic [1:0] act_tid;
    logic act_valid, drain_req, restart_valid;
    logic [PC_W-1:0] restart_pc;

    int tests = 0, fails = 0;
    bit done = 0;

    logic [1:0]  m_tid;
    logic [3:0]  m_blk;
    logic [15:0] m_pc [N];
    logic [15:0] lf = 16'hACE1;

    always #2 clk = ~clk;

    soe_thread_ctrl #(
        .N(N), .PC_W(PC_W), .SLICE_W(SW), .BOOT_PC(BPC),
        .BOOT_STRIDE(BST), .DEF_QUANTUM(200)
    ) dut_i (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_pick(input logic [3:0] el, input logic [3:0] pr,
                                            input logic [1:0] cur);
        for (int i = 1; i <= N; i++) if (el[(cur + i) % N] && pr[(cur + i) % N]) return 2'((cur + i) % N);
        for (int i = 1; i <= N; i++) if (el[(cur + i) % N]) return 2'((cur + i) % N);
        return cur;
    endfunction

    task automatic step_lf();
        for (int k = 0; k < 7; k++) lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    endtask

    // Called at a negedge while in DRAIN; ends at the first RUN negedge.
    task automatic finish_drain(input logic [3:0] rdy, input logic [3:0] pr);
        logic [3:0] el;
        logic [1:0] ex;
        thr_ready = rdy;
        thr_prio  = pr;
        el = rdy & ~m_blk;
        if (el == 0) begin
            pipe_empty = 1'b1;
            @(negedge clk);
            chk(drain_req, "R3 empty but none eligible", drain_req, 1);
            thr_wake = m_blk;
            @(negedge clk);
            thr_wake = '0;
            m_blk = '0;
            chk(drain_req, "R3 wake edge still draining", drain_req, 1);
            el = rdy;
        end else begin
            pipe_empty = 1'b1;
        end
        ex = exp_pick(el, pr, m_tid);
        @(negedge clk);
        pipe_empty = 1'b0;
        chk(restart_valid, "R4 refill cycle", restart_valid, 1);
        chk(act_tid == ex, "R7 pick", act_tid, ex);
        chk(restart_pc == m_pc[ex], "R5 restart pc", restart_pc, m_pc[ex]);
        @(negedge clk);
        chk(act_valid && !restart_valid, "R4 back to RUN", act_valid, 1);
        m_tid = ex;
    endtask

    // kind: 0 miss, 1 sync, 2 switch instruction
    task automatic do_switch(input int kind, input logic [15:0] rpc, input logic [3:0] rdy,
                             input logic [3:0] pr, input int dly);
        chk(act_valid && act_tid == m_tid, "R10 owner before event", act_tid, m_tid);
        ev_miss = (kind == 0);
        ev_sync = (kind == 1);
        ev_swi  = (kind == 2);
        cur_pc  = rpc;
        pipe_empty = 1'b0;
        @(negedge clk);
        ev_miss = 0; ev_sync = 0; ev_swi = 0;
        chk(drain_req && !act_valid, "R2 event drains", drain_req, 1);
        m_pc[m_tid] = rpc;
        if (kind != 2) m_blk[m_tid] = 1'b1;
        for (int d = 0; d < dly; d++) begin
            @(negedge clk);
            chk(drain_req, "R3 hold while not empty", drain_req, 1);
        end
        finish_drain(rdy, pr);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [3:0] rdy;
        m_tid = 2'd3;
        m_blk = '0;
        for (int t = 0; t < N; t++) m_pc[t] = BPC + 16'(t) * BST;
        repeat (3) @(negedge clk);
        chk(drain_req && !act_valid && !restart_valid, "R1 reset state", {act_valid, drain_req, restart_valid}, 3'b010);
        rst_n = 1'b1;
        chk(drain_req && !restart_valid, "R1 after release", drain_req, 1);
        finish_drain(4'hF, 4'h0);

        // R9: events during DRAIN are ignored; R7 current thread is last resort
        ev_swi = 1; cur_pc = 16'h0AA0; thr_ready = 4'(1) << m_tid;
        @(negedge clk);
        ev_swi = 0;
        m_pc[m_tid] = 16'h0AA0;
        chk(drain_req, "R2 swi drains", drain_req, 1);
        ev_miss = 1; ev_sync = 1; cur_pc = 16'hDEAD;
        @(negedge clk);
        ev_miss = 0; ev_sync = 0;
        chk(drain_req, "R9 drain unaffected", drain_req, 1);
        finish_drain(4'(1) << m_tid, 4'h0);

        // Randomized switch sequence
        for (int it = 0; it < 120; it++) begin
            step_lf();
            if (lf[14] && (m_blk != 0)) begin
                thr_wake = m_blk & lf[3:0];
                @(negedge clk);
                m_blk = m_blk & ~(lf[3:0]);
                thr_wake = '0;
                chk(act_valid, "R6 wake keeps RUN", act_valid, 1);
            end
            rdy = lf[7:4];
            if (rdy == 0) rdy = 4'(1) << lf[9:8];
            do_switch(int'(lf[1:0]) % 3, lf ^ 16'h5A5A, rdy, lf[13:10] & lf[3:0], int'(lf[15:14]));
        end

        // R8: quantum 5, loaded now, used from next refill
        q_we = 1; q_val = 8'd5;
        @(negedge clk);
        q_we = 0;
        do_switch(2, 16'h0123, 4'hF, 4'h0, 0);
        n = 1; cur_pc = 16'h4321;
        while (act_valid) begin @(negedge clk); if (act_valid) n++; end
        chk(n == 5, "R8 slice of 5", n, 5);
        chk(drain_req, "R8 preempt drains", drain_req, 1);
        m_pc[m_tid] = 16'h4321;
        finish_drain(4'hF, 4'h0);

        // R8: quantum 0 behaves as 1
        q_we = 1; q_val = 8'd0;
        n = 1;
        @(negedge clk);
        q_we = 0;
        n++;
        while (act_valid) begin @(negedge clk); if (act_valid) n++; end
        chk(n == 5, "R9 quantum write defers", n, 5);
        m_pc[m_tid] = 16'h4321;
        finish_drain(4'hF, 4'h2);
        n = 1;
        @(negedge clk);
        if (act_valid) n++;
        chk(n == 1 && drain_req, "R8 quantum 0 acts as 1", n, 1);
        m_pc[m_tid] = 16'h4321;
        finish_drain(4'hF, 4'h0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule